// File: doc/BRIEF.md
# Receive FIFO Pause Flow Controller

This block watches how many bytes sit in a receive FIFO and asks the MAC transmitter to send flow-control pause frames. When the fill level climbs past a high-water mark it asks for a stop frame that carries a programmed pause time. Once the level has drained to a low-water mark it asks for a resume frame, which is a pause frame with a time of zero. Using two marks gives hysteresis, so the block does not chatter around one level.

Both marks are programmed in 64-byte units through one 32-bit threshold word. Each request is held until the transmitter acknowledges it. If the pause state changes again before that acknowledge arrives, the newer request replaces the older one. A flow-control enable input returns the block to its unpaused state at once, and it does this without sending a resume frame. Building the frames and the MAC itself lie outside this block.

Top module: `rx_pause_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, `reqValid` is 0, `reqTime` is 0 and the block is unpaused.
- R2: In the unpaused state with `flowEn` high, a clock edge at which `fifoLevel` is strictly greater than 64 times the stop field raises `reqValid` after that edge, with `reqTime` equal to the `pauseTime` sampled at that edge. A level exactly equal to 64 times the stop field does nothing.
- R3: In the paused state with `flowEn` high, a clock edge at which `fifoLevel` is at or below 64 times the resume field raises `reqValid` after that edge, with `reqTime` equal to 0. A level one byte above that mark does nothing.
- R4: With a resume field of 0, the resume request is issued only when `fifoLevel` reaches 0.
- R5: The stop field is `threshCfg[8:0]` and the resume field is `threshCfg[20:12]`. All other bits of `threshCfg` have no effect.
- R6: One request is issued per state change. While the state stays the same, no new request is raised after an acknowledge, whatever `fifoLevel` does.
- R7: A raised request stays high until an edge at which `reqAck` is high. It is low after that edge unless a new state change happens at the same edge.
- R8: If the state changes while a request is still pending, `reqValid` stays high and `reqTime` takes the value of the new request.
- R9: With `flowEn` low, the block goes to the unpaused state and drops any pending request at the next edge. It raises no request while `flowEn` stays low. When `flowEn` goes high again it sends no resume frame.
- R10: A pending stop request keeps its `reqTime` even when `pauseTime` changes before the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| flowEn | input | 1 | Flow-control enable; low forces the unpaused state |
| fifoLevel | input | LEVEL_W (16) | Receive FIFO fill level in bytes |
| threshCfg | input | 32 | Stop field in [8:0] and resume field in [20:12], each in 64-byte units |
| pauseTime | input | TIME_W (16) | Pause time carried by stop requests |
| reqAck | input | 1 | Transmitter accepts the pending request |
| reqValid | output | 1 | A pause request is pending |
| reqTime | output | TIME_W (16) | Pause time of the pending request; 0 means resume |

## Verification
The assertions assume the resume mark is below the stop mark. When that holds, no single fill level can satisfy both the stop and the resume condition, and each state change follows from the comparison made at the previous edge. The stimulus always programs a resume field smaller than the stop field and keeps every stop field at or below 0x6F. Fill levels stay between 0 and 7200 bytes. The acknowledge and enable are driven freely, including an acknowledge in the same cycle as a new state change.

// File: rtl/pause_pkg.sv
package pause_pkg;
  localparam int CFG_W    = 32;
  localparam int THR_W    = 9;
  localparam int OFF_LSB  = 0;
  localparam int ON_LSB   = 12;
  localparam int QUANT_SH = 6;

  typedef enum logic {
    ST_FLOWING = 1'b0,
    ST_HELD    = 1'b1
  } pauseState_t;

  typedef struct packed {
    logic sendXoff;
    logic sendXon;
    logic withdraw;
  } pauseCmd_t;
endpackage

// File: rtl/pause_dp.sv
module pause_dp
  import pause_pkg::*;
#(
  parameter int LEVEL_W = 16,
  parameter int TIME_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LEVEL_W-1:0] fifoLevel,
  input  logic [CFG_W-1:0]  threshCfg,
  input  logic [TIME_W-1:0] pauseTime,
  input  pauseCmd_t         cmd,
  output logic              overOff,
  output logic              belowOn,
  output logic [TIME_W-1:0] reqTime
);
  localparam int SCALED_W = THR_W + QUANT_SH;
  localparam int CMP_W    = (LEVEL_W > SCALED_W) ? LEVEL_W : SCALED_W;

  logic [THR_W-1:0] offField;
  logic [THR_W-1:0] onField;
  logic [CMP_W-1:0] levelExt;
  logic [CMP_W-1:0] offBytes;
  logic [CMP_W-1:0] onBytes;

  assign offField = threshCfg[OFF_LSB +: THR_W];
  assign onField  = threshCfg[ON_LSB  +: THR_W];

  // Quantum scaling: each field unit is 2**QUANT_SH bytes.
  assign levelExt = CMP_W'(fifoLevel);
  assign offBytes = CMP_W'(offField) << QUANT_SH;
  assign onBytes  = CMP_W'(onField)  << QUANT_SH;

  assign overOff = levelExt > offBytes;
  assign belowOn = levelExt <= onBytes;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqTime <= '0;
    end else if (cmd.withdraw || cmd.sendXon) begin
      reqTime <= '0;
    end else if (cmd.sendXoff) begin
      reqTime <= pauseTime;
    end
  end
endmodule

// File: rtl/pause_ctl.sv
module pause_ctl
  import pause_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      flowEn,
  input  logic      overOff,
  input  logic      belowOn,
  input  logic      reqAck,
  output pauseCmd_t cmd,
  output logic      pausedQ,
  output logic      reqValid
);
  pauseState_t stateQ, stateD;

  always_comb begin
    cmd    = '0;
    stateD = stateQ;
    if (!flowEn) begin
      stateD       = ST_FLOWING;
      cmd.withdraw = 1'b1;
    end else begin
      case (stateQ)
        ST_FLOWING: if (overOff) begin
          stateD       = ST_HELD;
          cmd.sendXoff = 1'b1;
        end
        ST_HELD: if (belowOn) begin
          stateD      = ST_FLOWING;
          cmd.sendXon = 1'b1;
        end
        default: stateD = ST_FLOWING;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_FLOWING;
      reqValid <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (cmd.withdraw)                    reqValid <= 1'b0;
      else if (cmd.sendXoff || cmd.sendXon) reqValid <= 1'b1;
      else if (reqAck)                     reqValid <= 1'b0;
    end
  end

  assign pausedQ = (stateQ == ST_HELD);
endmodule

// File: rtl/rx_pause_ctrl.sv
module rx_pause_ctrl
  import pause_pkg::*;
#(
  parameter int LEVEL_W = 16,
  parameter int TIME_W  = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               flowEn,
  input  logic [LEVEL_W-1:0] fifoLevel,
  input  logic [31:0]        threshCfg,
  input  logic [TIME_W-1:0]  pauseTime,
  input  logic               reqAck,
  output logic               reqValid,
  output logic [TIME_W-1:0]  reqTime
);
  pauseCmd_t cmd;
  logic      overOff;
  logic      belowOn;
  logic      pausedQ;

  pause_dp #(.LEVEL_W(LEVEL_W), .TIME_W(TIME_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .fifoLevel (fifoLevel),
    .threshCfg (threshCfg),
    .pauseTime (pauseTime),
    .cmd       (cmd),
    .overOff   (overOff),
    .belowOn   (belowOn),
    .reqTime   (reqTime)
  );

  pause_ctl u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .flowEn   (flowEn),
    .overOff  (overOff),
    .belowOn  (belowOn),
    .reqAck   (reqAck),
    .cmd      (cmd),
    .pausedQ  (pausedQ),
    .reqValid (reqValid)
  );
endmodule

// File: rtl/pause_chk.sv
module pause_chk #(
  parameter int LEVEL_W = 16,
  parameter int TIME_W  = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               flowEn,
  input logic [LEVEL_W-1:0] fifoLevel,
  input logic [31:0]        threshCfg,
  input logic [TIME_W-1:0]  pauseTime,
  input logic               reqAck,
  input logic               reqValid,
  input logic [TIME_W-1:0]  reqTime,
  input logic               pausedQ
);
  // Entering pause: level was above the stop mark, time was captured.
  assert_xoff_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pausedQ) |-> reqValid && (reqTime == $past(pauseTime)) &&
      (32'($past(fifoLevel)) > (32'($past(threshCfg[8:0])) << 6)));

  // Leaving pause while enabled: resume request with zero time, level at/below mark.
  assert_xon_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pausedQ) && $past(flowEn) |-> reqValid && (reqTime == '0) &&
      (32'($past(fifoLevel)) <= (32'($past(threshCfg[20:12])) << 6)));

  assert_one_per_change_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqValid) |-> !$stable(pausedQ));

  assert_hold_until_ack_R7: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqAck && flowEn |=> reqValid);

  assert_disable_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !flowEn |=> !reqValid && !pausedQ);

  assert_time_kept_R10: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqAck && flowEn |=> (!$stable(pausedQ) || $stable(reqTime)));
endmodule

bind rx_pause_ctrl pause_chk #(.LEVEL_W(LEVEL_W), .TIME_W(TIME_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .flowEn    (flowEn),
  .fifoLevel (fifoLevel),
  .threshCfg (threshCfg),
  .pauseTime (pauseTime),
  .reqAck    (reqAck),
  .reqValid  (reqValid),
  .reqTime   (reqTime),
  .pausedQ   (pausedQ)
);

// File: tb/test_rx_pause_ctrl.sv
`timescale 1ns/1ps
module test_rx_pause_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        flowEn = 1'b1;
  logic [15:0] fifoLevel = '0;
  logic [31:0] threshCfg = '0;
  logic [15:0] pauseTime = '0;
  logic        reqAck = 1'b0;
  logic        reqValid;
  logic [15:0] reqTime;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // Behavioural reference state
  bit mPaused = 0;
  bit mValid  = 0;
  int mTime   = 0;

  always #10 clk = ~clk;

  rx_pause_ctrl i_rx_pause_ctrl (
    .clk(clk), .rstN(rstN), .flowEn(flowEn), .fifoLevel(fifoLevel),
    .threshCfg(threshCfg), .pauseTime(pauseTime), .reqAck(reqAck),
    .reqValid(reqValid), .reqTime(reqTime)
  );

  function automatic logic [31:0] mkCfg(int offU, int onU, bit junk);
    logic [31:0] v;
    v = junk ? 32'hFFE0_0E00 : 32'h0;
    v[8:0]   = 9'(offU);
    v[20:12] = 9'(onU);
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mPaused = 0; mValid = 0; mTime = 0;
    end else if (!flowEn) begin
      mPaused = 0; mValid = 0;
    end else begin
      int offB, onB, lvl;
      bit fired;
      offB  = int'(threshCfg[8:0]) * 64;
      onB   = int'(threshCfg[20:12]) * 64;
      lvl   = int'(fifoLevel);
      fired = 0;
      if (!mPaused && lvl > offB) begin
        mPaused = 1; mValid = 1; mTime = int'(pauseTime); fired = 1;
      end else if (mPaused && lvl <= onB) begin
        mPaused = 0; mValid = 1; mTime = 0; fired = 1;
      end
      if (!fired && reqAck) mValid = 0;
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check(reqValid == mValid, "R6 R7 valid", int'(reqValid), int'(mValid));
      if (mValid)
        check(int'(reqTime) == mTime, "R2 R3 time", int'(reqTime), mTime);
    end
  end

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectReq(bit v, int t, string req);
    check(reqValid == v, req, int'(reqValid), int'(v));
    if (v) check(int'(reqTime) == t, req, int'(reqTime), t);
  endtask

  task automatic ackOnce();
    reqAck = 1; cyc(); reqAck = 0;
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    threshCfg = mkCfg(16, 4, 0);
    pauseTime = 16'h1234;
    cyc(3);
    check(reqValid == 0, "R1 reset valid", int'(reqValid), 0);
    check(reqTime == 0, "R1 reset time", int'(reqTime), 0);
    rstN = 1;
    cyc();
    expectReq(0, 0, "R1 after reset");

    // R2 boundary: equal to stop mark does nothing
    fifoLevel = 1024; cyc(); expectReq(0, 0, "R2 equal level");
    fifoLevel = 1025; cyc(); expectReq(1, 16'h1234, "R2 stop request");
    // R10/R7: hold, time captured
    pauseTime = 16'h9999; cyc(3); expectReq(1, 16'h1234, "R10 time kept");
    ackOnce(); expectReq(0, 0, "R7 cleared by ack");
    fifoLevel = 3000; cyc(5); expectReq(0, 0, "R6 no repeat stop");

    // R3 boundary
    fifoLevel = 257; cyc(2); expectReq(0, 0, "R3 above resume mark");
    fifoLevel = 256; cyc(); expectReq(1, 0, "R3 resume request");
    ackOnce(); fifoLevel = 100; cyc(4); expectReq(0, 0, "R6 no repeat resume");

    // R8 replacement
    pauseTime = 16'h00AB;
    fifoLevel = 2000; cyc(); expectReq(1, 16'h00AB, "R8 stop pending");
    fifoLevel = 0; cyc(); expectReq(1, 0, "R8 replaced by resume");
    ackOnce(); expectReq(0, 0, "R8 acked");

    // R5: junk bits elsewhere ignored
    threshCfg = mkCfg(16, 4, 1);
    fifoLevel = 1024; cyc(2); expectReq(0, 0, "R5 junk bits equal level");
    fifoLevel = 1025; cyc(); expectReq(1, 16'h00AB, "R5 stop field position");
    ackOnce();
    fifoLevel = 300; cyc(); expectReq(0, 0, "R5 resume field position high");
    fifoLevel = 256; cyc(); expectReq(1, 0, "R5 resume field position");
    ackOnce();

    // R4: resume field 0
    threshCfg = mkCfg(8, 0, 0);
    fifoLevel = 600; cyc(); expectReq(1, 16'h00AB, "R4 stop");
    ackOnce();
    fifoLevel = 1; cyc(3); expectReq(0, 0, "R4 level one no resume");
    fifoLevel = 0; cyc(); expectReq(1, 0, "R4 resume at empty");
    ackOnce();

    // R9: disable
    fifoLevel = 1000; cyc(); expectReq(1, 16'h00AB, "R9 stop pending");
    flowEn = 0; cyc(); expectReq(0, 0, "R9 withdrawn");
    fifoLevel = 0; cyc(3); expectReq(0, 0, "R9 silent while off");
    flowEn = 1; cyc(2); expectReq(0, 0, "R9 no resume on enable");
    fifoLevel = 600; cyc(); expectReq(1, 16'h00AB, "R9 unpaused after enable");
    ackOnce();

    // Free-running phase, compared against the reference each cycle
    threshCfg = mkCfg(64, 32, 0);
    for (int i = 0; i < 2000; i++) begin
      fifoLevel = 16'($urandom_range(0, 7200));
      reqAck    = ($urandom_range(0, 2) == 0);
      flowEn    = ($urandom_range(0, 39) != 0);
      if (i % 97 == 0) pauseTime = 16'($urandom);
      if (i % 500 == 250) threshCfg = mkCfg(int'($urandom_range(10, 111)), int'($urandom_range(0, 9)), 1);
      cyc();
    end
    reqAck = 0; flowEn = 1;
    cyc(2);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule